// File: doc/BRIEF.md
# Boot VID Target Sequencer

This block holds the voltage targets for a three-output regulator controller: two switching-regulator channels (0 and 1) and one buffered channel (2). After reset it is in a boot phase. All three targets climb from zero towards a boot voltage. Two static select pins and a debug-table select pick that voltage. Once the targets sit at the boot voltage and the internal power-good status is high, the boot value is frozen.

A rising edge on the external power-good input hands control to a decoded serial write port. That port sets each channel on its own from a 7-bit VID code. A falling edge on that input at any later time sends all three targets back to the frozen boot value and returns the block to boot mode. An optional droop offset of +2 units is added to the two switching channels.

All targets are expressed in 6.25 mV units. A VID code `c` maps to `248 - 2*c` units, floored at 0.

Top module: `vid_target_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, all three targets read 0 and `mode_o` reads 0. Mode encoding: 0 = boot ramp, 1 = boot held, 2 = serial.
- R2: With `debug_i` low, `boot_sel_i` values 0, 1, 2 and 3 give boot targets of 176, 160, 144 and 128 units.
- R3: With `debug_i` high, `boot_sel_i` values 0, 1, 2 and 3 give boot targets of 224, 192, 160 and 128 units.
- R4: In mode 0, all three targets move together by one unit every `RAMP_DIV` cycles towards the current boot target. A change on `boot_sel_i` re-aims them at the new value, up or down.
- R5: When all targets equal the boot target and `pwr_ok_i` is high in mode 0, the boot target is frozen and the mode becomes 1. With `debug_i` low, later `boot_sel_i` changes leave the targets unchanged.
- R6: A rising edge on `pgd_in_i` in mode 1 sets the mode to 2. A rising edge in mode 0 does nothing.
- R7: In mode 2, a strobe on `wr_valid_i` with `wr_chan_i` equal to 0, 1 or 2 sets only that channel to `248 - 2*wr_code_i` units, floored at 0. The value appears two cycles later. Channel select 3 is ignored.
- R8: Writes that arrive in mode 0 or mode 1 are ignored.
- R9: A falling edge on `pgd_in_i` in mode 1 or mode 2 loads the frozen boot target into all three channels and sets the mode to 1. From two cycles later, all three targets are equal.
- R10: With `debug_i` high, in mode 1 while `pgd_in_i` is low, `boot_sel_i` changes keep re-aiming the targets, one unit per `RAMP_DIV` cycles. The frozen value stays unchanged.
- R11: Channels 0 and 1 read +2 units above their stored value only when all three hold: mode is 2, `offset_en_i` is high, and the low-power flag of the most recent accepted write is clear. Channel 2 never gets the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_sel_i | input | 2 | Boot-voltage select pins |
| debug_i | input | 1 | Selects the debug boot table and keeps the pins live after freeze |
| pgd_in_i | input | 1 | External power-good handshake |
| pwr_ok_i | input | 1 | Internal power-good status |
| offset_en_i | input | 1 | Enables the droop offset |
| wr_valid_i | input | 1 | Single-cycle serial write strobe |
| wr_chan_i | input | SELW | Channel select of a write |
| wr_code_i | input | CW | VID code of a write |
| wr_lowpwr_i | input | 1 | Low-power flag carried by a write |
| tgt_o | output | NCH x TW | Registered target per channel, in 6.25 mV units |
| mode_o | output | 2 | Current mode |

## Verification
The hardest situation to reach is the revert path: the block must be in serial mode with channels that differ and with the offset active, and then see a falling power-good edge. The bench gets there by finishing a full boot ramp, raising power-good, writing distinct codes to each channel, turning the offset on, and then dropping power-good. It then re-raises power-good to show that the offset returns on top of the frozen value. A second run after reset covers the debug table. That run also repeats the revert with the pins aimed back at the frozen value, so the live debug slew cannot mask the load.

// File: rtl/vts_pkg.sv
package vts_pkg;

  typedef enum logic [1:0] {
    MODE_RAMP   = 2'd0,
    MODE_HELD   = 2'd1,
    MODE_SERIAL = 2'd2
  } vts_mode_e;

  // Boot target in 6.25 mV units for a select-pin pair and table choice.
  function automatic int boot_units(input logic dbg, input logic [1:0] sel);
    if (dbg) begin
      case (sel)
        2'd0:    return 224;
        2'd1:    return 192;
        2'd2:    return 160;
        default: return 128;
      endcase
    end
    return 176 - 16 * int'(sel);
  endfunction

endpackage

// File: rtl/vts_boot_lut.sv
module vts_boot_lut #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic [1:0]    sel_i,
  input  logic          dbg_i,
  output logic [TW-1:0] boot_q
);
  // Deliberately not reset: the value is already valid when reset is released.
  always_ff @(posedge clk) begin
    boot_q <= TW'(vts_pkg::boot_units(dbg_i, sel_i));
  end
endmodule

// File: rtl/vts_slew_chan.sv
module vts_slew_chan #(
  parameter int TW       = 8,
  parameter int CW       = 7,
  parameter int VID_TOP  = 248,
  parameter int VID_STEP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  logic [TW-1:0] tgt_i,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  input  logic          wr_i,
  input  logic [CW-1:0] wr_code_i,
  output logic [TW-1:0] base_o,
  output logic          at_tgt_o
);
  int          prod_c;
  logic [TW-1:0] wr_units;

  always_comb begin
    prod_c   = int'(wr_code_i) * VID_STEP;
    wr_units = (prod_c >= VID_TOP) ? '0 : TW'(VID_TOP - prod_c);
  end

  // Priority: revert load, then serial write, then one-unit slew.
  always_ff @(posedge clk) begin
    if (rst) begin
      base_o <= '0;
    end else if (load_i) begin
      base_o <= load_val_i;
    end else if (wr_i) begin
      base_o <= wr_units;
    end else if (step_i && (base_o < tgt_i)) begin
      base_o <= base_o + 1'b1;
    end else if (step_i && (base_o > tgt_i)) begin
      base_o <= base_o - 1'b1;
    end
  end

  assign at_tgt_o = (base_o == tgt_i);
endmodule

// File: rtl/vts_out_stage.sv
module vts_out_stage #(
  parameter int TW     = 8,
  parameter int NCH    = 3,
  parameter int NOFF   = 2,
  parameter int OFFSET = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0][TW-1:0]  base_i,
  input  logic                    add_off_i,
  output logic [NCH-1:0][TW-1:0]  tgt_o
);
  localparam logic [TW:0] OFF_W = (TW+1)'(OFFSET);
  localparam logic [TW-1:0] SAT = {TW{1'b1}};

  logic [NCH-1:0][TW-1:0] nxt;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    if (g < NOFF) begin : g_off
      logic [TW:0] sum;
      assign sum    = {1'b0, base_i[g]} + (add_off_i ? OFF_W : '0);
      assign nxt[g] = sum[TW] ? SAT : sum[TW-1:0];
    end else begin : g_plain
      assign nxt[g] = base_i[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tgt_o <= '0;
    else     tgt_o <= nxt;
  end
endmodule

// File: rtl/vid_target_seq.sv
module vid_target_seq
  import vts_pkg::*;
#(
  parameter int TW       = 8,
  parameter int CW       = 7,
  parameter int NCH      = 3,
  parameter int NOFF     = 2,
  parameter int RAMP_DIV = 4,
  parameter int VID_TOP  = 248,
  parameter int VID_STEP = 2,
  parameter int OFFSET   = 2,
  localparam int SELW    = (NCH > 1) ? $clog2(NCH + 1) : 1,
  localparam int DIVW    = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              boot_sel_i,
  input  logic                    debug_i,
  input  logic                    pgd_in_i,
  input  logic                    pwr_ok_i,
  input  logic                    offset_en_i,
  input  logic                    wr_valid_i,
  input  logic [SELW-1:0]         wr_chan_i,
  input  logic [CW-1:0]           wr_code_i,
  input  logic                    wr_lowpwr_i,
  output logic [NCH-1:0][TW-1:0]  tgt_o,
  output logic [1:0]              mode_o
);
  localparam logic [DIVW-1:0] DIV_LAST = DIVW'(RAMP_DIV - 1);

  vts_mode_e              state_q;
  logic                   pgd_q;
  logic                   lp_q;
  logic [DIVW-1:0]        div_q;
  logic [TW-1:0]          boot_val;
  logic [TW-1:0]          frozen_q;
  logic [NCH-1:0][TW-1:0] base;
  logic [NCH-1:0]         at_vec;
  logic                   tick, pg_rise, pg_fall, slew_ok, load_all, wr_ok;

  vts_boot_lut #(.TW(TW)) u_lut (
    .clk(clk), .sel_i(boot_sel_i), .dbg_i(debug_i), .boot_q(boot_val)
  );

  // Slew prescaler.
  always_ff @(posedge clk) begin
    if (rst || div_q == DIV_LAST) div_q <= '0;
    else                          div_q <= div_q + 1'b1;
  end
  assign tick = (div_q == DIV_LAST);

  assign pg_rise  = pgd_in_i & ~pgd_q;
  assign pg_fall  = ~pgd_in_i & pgd_q;
  assign load_all = pg_fall && (state_q != MODE_RAMP);
  assign wr_ok    = wr_valid_i && (state_q == MODE_SERIAL);
  assign slew_ok  = tick && ((state_q == MODE_RAMP) ||
                    ((state_q == MODE_HELD) && debug_i && !pgd_in_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= MODE_RAMP;
      pgd_q    <= 1'b0;
      frozen_q <= '0;
      lp_q     <= 1'b0;
    end else begin
      pgd_q <= pgd_in_i;
      if (wr_ok && (int'(wr_chan_i) < NCH) && !load_all) lp_q <= wr_lowpwr_i;
      case (state_q)
        MODE_RAMP: begin
          if ((&at_vec) && pwr_ok_i) begin
            frozen_q <= boot_val;
            state_q  <= MODE_HELD;
          end
        end
        MODE_HELD: begin
          if (pg_rise) state_q <= MODE_SERIAL;
        end
        MODE_SERIAL: begin
          if (pg_fall) state_q <= MODE_HELD;
        end
        default: state_q <= MODE_RAMP;
      endcase
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    vts_slew_chan #(
      .TW(TW), .CW(CW), .VID_TOP(VID_TOP), .VID_STEP(VID_STEP)
    ) u_chan (
      .clk        (clk),
      .rst        (rst),
      .step_i     (slew_ok),
      .tgt_i      (boot_val),
      .load_i     (load_all),
      .load_val_i (frozen_q),
      .wr_i       (wr_ok && (wr_chan_i == SELW'(c))),
      .wr_code_i  (wr_code_i),
      .base_o     (base[c]),
      .at_tgt_o   (at_vec[c])
    );
  end

  vts_out_stage #(
    .TW(TW), .NCH(NCH), .NOFF(NOFF), .OFFSET(OFFSET)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .base_i    (base),
    .add_off_i ((state_q == MODE_SERIAL) && offset_en_i && !lp_q),
    .tgt_o     (tgt_o)
  );

  assign mode_o = state_q;
endmodule

// File: rtl/vts_checker.sv
module vts_checker #(
  parameter int TW       = 8,
  parameter int CW       = 7,
  parameter int NCH      = 3,
  parameter int SELW     = 2,
  parameter int VID_TOP  = 248,
  parameter int VID_STEP = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   pgd_in_i,
  input logic                   debug_i,
  input logic                   wr_valid_i,
  input logic [SELW-1:0]        wr_chan_i,
  input logic [CW-1:0]          wr_code_i,
  input logic [NCH-1:0][TW-1:0] tgt_o,
  input logic [1:0]             mode_o
);
  logic [TW-1:0] chk_units;
  always_comb begin
    if (int'(wr_code_i) * VID_STEP >= VID_TOP) chk_units = '0;
    else chk_units = TW'(VID_TOP - int'(wr_code_i) * VID_STEP);
  end

  // R6: boot ramp never jumps straight to serial mode.
  a_r6_no_skip: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd0) |=> (mode_o != 2'd2));

  // R9: falling handshake after freeze returns to held boot mode.
  a_r9_revert_mode: assert property (@(posedge clk) disable iff (rst)
    ($fell(pgd_in_i) && (mode_o != 2'd0)) |=> (mode_o == 2'd1));

  // R9: once settled in boot-held mode, the channels agree.
  a_r9_boot_uniform: assert property (@(posedge clk) disable iff (rst)
    ((mode_o == 2'd1) && ($past(mode_o) == 2'd1)) |->
      ((tgt_o[0] == tgt_o[1]) && (tgt_o[1] == tgt_o[NCH-1])));

  // R7: a serial write to the last channel shows up two cycles later.
  a_r7_write_last: assert property (@(posedge clk) disable iff (rst)
    ((mode_o == 2'd2) && wr_valid_i && pgd_in_i && (wr_chan_i == SELW'(NCH-1)))
      |=> ##1 (tgt_o[NCH-1] == $past(chk_units, 2)));

  // R5: frozen boot value does not move in normal mode.
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
    ((mode_o == 2'd1) && ($past(mode_o) == 2'd1) && ($past(mode_o, 2) == 2'd1) &&
     !$past(debug_i) && !$past(debug_i, 2)) |-> $stable(tgt_o));
endmodule

bind vid_target_seq vts_checker #(
  .TW(TW), .CW(CW), .NCH(NCH), .SELW(SELW), .VID_TOP(VID_TOP), .VID_STEP(VID_STEP)
) u_chk (
  .clk(clk), .rst(rst), .pgd_in_i(pgd_in_i), .debug_i(debug_i),
  .wr_valid_i(wr_valid_i), .wr_chan_i(wr_chan_i), .wr_code_i(wr_code_i),
  .tgt_o(tgt_o), .mode_o(mode_o)
);

// File: tb/vid_target_seq_tb_top.sv
`timescale 1ns/1ps
module vid_target_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] boot_sel = 2'd0;
  logic debug = 1'b0, pgd_in = 1'b0, pwr_ok = 1'b0, off_en = 1'b0;
  logic wr_valid = 1'b0, wr_lp = 1'b0;
  logic [1:0] wr_chan = 2'd0;
  logic [6:0] wr_code = 7'd0;
  logic [2:0][7:0] tgt;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;

  typedef struct { string req; int ch; int exp; } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  vid_target_seq dut_i (
    .clk(clk), .rst(rst), .boot_sel_i(boot_sel), .debug_i(debug),
    .pgd_in_i(pgd_in), .pwr_ok_i(pwr_ok), .offset_en_i(off_en),
    .wr_valid_i(wr_valid), .wr_chan_i(wr_chan), .wr_code_i(wr_code),
    .wr_lowpwr_i(wr_lp), .tgt_o(tgt), .mode_o(mode)
  );

  // Monitor: drains expected items at the falling edge.
  always @(negedge clk) begin
    item_t it;
    int act;
    while (exp_q.size() > 0) begin
      it  = exp_q.pop_front();
      act = (it.ch == 3) ? int'(mode) : int'(tgt[it.ch]);
      checks++;
      if (act != it.exp) begin
        errors++;
        $display("FAIL %s ch%0d actual %0d expected %0d", it.req, it.ch, act, it.exp);
      end
    end
  end

  function automatic int units(input int code);
    return (2 * code >= 248) ? 0 : 248 - 2 * code;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: push expected values for three channels and the mode.
  task automatic expect4(input string req, input int a, input int b, input int c, input int m);
    exp_q.push_back('{req, 0, a});
    exp_q.push_back('{req, 1, b});
    exp_q.push_back('{req, 2, c});
    exp_q.push_back('{req, 3, m});
    @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wr(input int ch, input int code, input bit lp);
    @(negedge clk);
    wr_valid = 1'b1; wr_chan = 2'(ch); wr_code = 7'(code); wr_lp = lp;
    @(negedge clk);
    wr_valid = 1'b0;
    cyc(3);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(4);
    expect4("R1 reset", 0, 0, 0, 0);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Normal-table run.
    do_reset();
    cyc(100);
    check(tgt[0] == tgt[1] && tgt[1] == tgt[2], "R4 lockstep", int'(tgt[2]), int'(tgt[0]));
    check(tgt[0] > 0 && tgt[0] < 176, "R4 partial ramp", int'(tgt[0]), 25);
    boot_sel = 2'd3; cyc(1000);
    expect4("R4 retarget", 128, 128, 128, 0);
    boot_sel = 2'd2; cyc(200);
    expect4("R2 sel2", 144, 144, 144, 0);
    boot_sel = 2'd1; cyc(200);
    expect4("R2 sel1", 160, 160, 160, 0);
    pgd_in = 1'b1; cyc(3); pgd_in = 1'b0; cyc(3);
    expect4("R6 early rise ignored", 160, 160, 160, 0);
    boot_sel = 2'd0; cyc(200);
    expect4("R2 sel0", 176, 176, 176, 0);
    pwr_ok = 1'b1; cyc(5);
    expect4("R5 freeze", 176, 176, 176, 1);
    boot_sel = 2'd3; cyc(300);
    expect4("R5 pins ignored", 176, 176, 176, 1);
    wr(0, 16, 0);
    expect4("R8 write in boot", 176, 176, 176, 1);
    pgd_in = 1'b1; cyc(3);
    expect4("R6 enter serial", 176, 176, 176, 2);
    wr(0, 32, 0);
    expect4("R7 ch0", 184, 176, 176, 2);
    wr(2, 0, 0);
    expect4("R7 ch2", 184, 176, 248, 2);
    wr(1, 127, 0);
    expect4("R7 ch1 floor", 184, 0, 248, 2);
    wr(3, 0, 0);
    expect4("R7 ch3 ignored", 184, 0, 248, 2);
    off_en = 1'b1; cyc(3);
    expect4("R11 offset on", 186, 2, 248, 2);
    wr(1, 40, 1);
    expect4("R11 lowpower blocks", 184, 168, 248, 2);
    wr(1, 40, 0);
    expect4("R11 offset back", 186, 170, 248, 2);
    pgd_in = 1'b0; cyc(3);
    expect4("R9 revert", 176, 176, 176, 1);
    pgd_in = 1'b1; cyc(3);
    expect4("R11 offset on frozen", 178, 178, 176, 2);

    // Debug-table run.
    off_en = 1'b0; pgd_in = 1'b0; debug = 1'b1; boot_sel = 2'd1;
    do_reset();
    cyc(900);
    expect4("R3 sel1 freeze", 192, 192, 192, 1);
    boot_sel = 2'd0; cyc(200);
    expect4("R10 live sel0", 224, 224, 224, 1);
    boot_sel = 2'd2; cyc(300);
    expect4("R3 sel2", 160, 160, 160, 1);
    boot_sel = 2'd3; cyc(200);
    expect4("R3 sel3", 128, 128, 128, 1);
    boot_sel = 2'd1;
    pgd_in = 1'b1; cyc(3);
    wr(0, 0, 0);
    expect4("R7 debug write", 248, 128, 128, 2);
    pgd_in = 1'b0; cyc(3);
    expect4("R9 revert frozen", 192, 192, 192, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule